// File: doc/BRIEF.md
# Supply-Fail Write-Protect Supervisor

This block decides whether a memory may be accessed, based on how healthy the main supply is. It watches three comparator flags, each already turned into a digital level. Each flag says whether the supply is above one of three thresholds:

- the full-operation level (about 4.5 V);
- the write-protect trip level (about 4.25 V);
- the switchover level (about 2.7 V).

From these flags it drives four commands:

- an access lockout;
- a command that floats the memory outputs;
- a command that selects the backup battery in place of the main supply;
- single-cycle pulses marking supply-good and supply-fail events, for downstream timers.

Each flag passes through its own debounce filter. A flag is accepted only after it has held a new value for `DEB_CYCLES` consecutive clock edges. The filtered flags are then sorted into a supply level:

| Level | Meaning | Flag pattern {full, trip, switch} |
|-------|---------|-----------------------------------|
| FULL | above the full-operation level | 111 |
| MID | between the trip and full-operation levels | 011 |
| LOW | between the switchover and trip levels | 001 |
| DEAD | below the switchover level, or any inconsistent pattern | anything else |

A four-state machine acts on this level. Its states are NORMAL, PROTECT, BATTERY and RECOVER, and its transitions are:

| From | To | Condition | Transition name |
|------|----|-----------|-----------------|
| NORMAL | PROTECT | LOW | trip |
| NORMAL, PROTECT, RECOVER | BATTERY | DEAD | switch-down |
| BATTERY | RECOVER | anything but DEAD | switch-up |
| PROTECT, RECOVER | NORMAL | FULL | resume |

In every other case the state holds. In particular NORMAL holds in MID, which gives hysteresis: access is lost at the trip level but regained only at the full-operation level. After reset the block sits in BATTERY, the safest assumption about an unknown supply.

Top module: `supply_guard`

## Requirements
- R1: While reset is held and right after it, lockout, output-float and battery-select are 1, and both pulses are 0 (state BATTERY).
- R2: A change on any raw flag that lasts fewer than DEB_CYCLES consecutive clock edges has no effect on any output.
- R3: A flag pattern {full, trip, switch} other than 111, 011 or 001 is treated as DEAD (below switchover). For example, 110 or 101 drives the block into BATTERY.
- R4: In NORMAL, lockout, output-float and battery-select are all 0. NORMAL is kept while the level is FULL or MID.
- R5: From NORMAL, level LOW enters PROTECT. PROTECT sets lockout and output-float to 1 and battery-select to 0.
- R6: Level DEAD enters BATTERY from any state. In BATTERY, battery-select, lockout and output-float are all 1.
- R7: From BATTERY, any level other than DEAD enters RECOVER. RECOVER sets battery-select to 0 and keeps lockout and output-float at 1. BATTERY never goes straight to NORMAL.
- R8: PROTECT and RECOVER return to NORMAL only when the level is FULL. Level MID keeps access locked.
- R9: pwr_good_pulse is high for exactly one cycle when the level moves from LOW/DEAD to MID/FULL. It appears in the same cycle as the state update for that level.
- R10: pwr_fail_pulse is high for exactly one cycle when the level moves from MID/FULL to LOW/DEAD. It appears in the same cycle as the state update.
- R11: After a raw flag changes and holds, the outputs change on the (DEB_CYCLES+1)-th clock edge: DEB_CYCLES edges in the filter and one in the state register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sup_above_full | input | 1 | Supply above full-operation level |
| sup_above_trip | input | 1 | Supply above write-protect trip level |
| sup_above_switch | input | 1 | Supply above battery switchover level |
| acc_lockout | output | 1 | Memory access disallowed |
| bus_hiz | output | 1 | Command to float memory outputs |
| batt_select | output | 1 | Command to power the memory from the backup battery |
| pwr_good_pulse | output | 1 | One-cycle pulse when the supply rises through the trip level |
| pwr_fail_pulse | output | 1 | One-cycle pulse when the supply falls through the trip level |

## Verification
The bench runs short glitches, one edge shorter than the filter window. A filter that counted total cycles instead of consecutive cycles would let such a glitch through as a spurious lockout.

It parks the supply in the MID band from both sides. A design without hysteresis would either drop access early while in NORMAL, or unlock too early from PROTECT or RECOVER.

Inconsistent flag patterns are applied to make sure they select the battery rather than being read as a healthy supply. The exact edge on which each output moves is compared against an independent cycle model, so a missing or extra pipeline stage would show up as an output one cycle off.

// File: rtl/supply_guard_pkg.sv
package supply_guard_pkg;

    typedef enum logic [1:0] {
        LVL_DEAD = 2'd0,
        LVL_LOW  = 2'd1,
        LVL_MID  = 2'd2,
        LVL_FULL = 2'd3
    } level_t;

    typedef enum logic [1:0] {
        ST_NORMAL  = 2'd0,
        ST_PROTECT = 2'd1,
        ST_BATTERY = 2'd2,
        ST_RECOVER = 2'd3
    } guard_state_t;

    localparam int FLAG_COUNT = 3;
    localparam int IDX_SWITCH = 0;
    localparam int IDX_TRIP   = 1;
    localparam int IDX_FULL   = 2;

endpackage

// File: rtl/supply_guard_filter.sv
module supply_guard_filter #(
    parameter int DEB_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_in,
    output logic filt_out
);
    localparam int CNT_W = (DEB_CYCLES > 1) ? $clog2(DEB_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DEB_CYCLES - 1);

    logic [CNT_W-1:0] run_cnt;

    // Accept a new value only after DEB_CYCLES consecutive differing samples.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            filt_out <= 1'b0;
            run_cnt  <= '0;
        end else if (raw_in == filt_out) begin
            run_cnt <= '0;
        end else if (run_cnt == CNT_LAST) begin
            filt_out <= raw_in;
            run_cnt  <= '0;
        end else begin
            run_cnt <= run_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/supply_guard_classify.sv
module supply_guard_classify
    import supply_guard_pkg::*;
(
    input  logic [FLAG_COUNT-1:0] flags,
    output level_t                level
);
    always_comb begin
        unique case (flags)
            3'b111:  level = LVL_FULL;
            3'b011:  level = LVL_MID;
            3'b001:  level = LVL_LOW;
            default: level = LVL_DEAD;   // below switchover or inconsistent
        endcase
    end
endmodule

// File: rtl/supply_guard_fsm.sv
module supply_guard_fsm
    import supply_guard_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  level_t level,
    output logic   lockout,
    output logic   hiz,
    output logic   batt_sel,
    output logic   good_pulse,
    output logic   fail_pulse
);
    guard_state_t state_q, state_d;
    logic         above_trip_q;
    logic         good_q, fail_q;
    logic         above_trip_now;

    assign above_trip_now = (level == LVL_MID) || (level == LVL_FULL);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_NORMAL: begin
                if (level == LVL_DEAD)      state_d = ST_BATTERY;
                else if (level == LVL_LOW)  state_d = ST_PROTECT;
            end
            ST_PROTECT: begin
                if (level == LVL_DEAD)      state_d = ST_BATTERY;
                else if (level == LVL_FULL) state_d = ST_NORMAL;
            end
            ST_BATTERY: begin
                if (level != LVL_DEAD)      state_d = ST_RECOVER;
            end
            ST_RECOVER: begin
                if (level == LVL_DEAD)      state_d = ST_BATTERY;
                else if (level == LVL_FULL) state_d = ST_NORMAL;
            end
            default:                        state_d = ST_BATTERY;
        endcase
    end

    // State register, with the trip-crossing tracker.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q      <= ST_BATTERY;
            above_trip_q <= 1'b0;
            good_q       <= 1'b0;
            fail_q       <= 1'b0;
        end else begin
            state_q      <= state_d;
            above_trip_q <= above_trip_now;
            good_q       <= above_trip_now && !above_trip_q;
            fail_q       <= !above_trip_now && above_trip_q;
        end
    end

    // Outputs.
    always_comb begin
        lockout    = 1'b1;
        hiz        = 1'b1;
        batt_sel   = 1'b0;
        unique case (state_q)
            ST_NORMAL: begin
                lockout = 1'b0;
                hiz     = 1'b0;
            end
            ST_PROTECT, ST_RECOVER: ;
            ST_BATTERY: batt_sel = 1'b1;
            default:    batt_sel = 1'b1;
        endcase
        good_pulse = good_q;
        fail_pulse = fail_q;
    end
endmodule

// File: rtl/supply_guard.sv
module supply_guard
    import supply_guard_pkg::*;
#(
    parameter int DEB_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sup_above_full,
    input  logic sup_above_trip,
    input  logic sup_above_switch,
    output logic acc_lockout,
    output logic bus_hiz,
    output logic batt_select,
    output logic pwr_good_pulse,
    output logic pwr_fail_pulse
);
    logic [FLAG_COUNT-1:0] flag_raw;
    logic [FLAG_COUNT-1:0] flag_filt;
    level_t                sup_level;

    always_comb begin
        flag_raw             = '0;
        flag_raw[IDX_FULL]   = sup_above_full;
        flag_raw[IDX_TRIP]   = sup_above_trip;
        flag_raw[IDX_SWITCH] = sup_above_switch;
    end

    for (genvar g = 0; g < FLAG_COUNT; g++) begin : g_filt
        supply_guard_filter #(.DEB_CYCLES(DEB_CYCLES)) u_filt (
            .clk      (clk),
            .rst_n    (rst_n),
            .raw_in   (flag_raw[g]),
            .filt_out (flag_filt[g])
        );
    end

    supply_guard_classify u_class (
        .flags (flag_filt),
        .level (sup_level)
    );

    supply_guard_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .level      (sup_level),
        .lockout    (acc_lockout),
        .hiz        (bus_hiz),
        .batt_sel   (batt_select),
        .good_pulse (pwr_good_pulse),
        .fail_pulse (pwr_fail_pulse)
    );
endmodule

// File: rtl/supply_guard_checker.sv
module supply_guard_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] filt,
    input logic       lockout,
    input logic       hiz,
    input logic       batt_sel,
    input logic       good,
    input logic       fail
);
    a_r4_normal_all_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !lockout |-> (!hiz && !batt_sel));

    a_r6_battery_locked: assert property (@(posedge clk) disable iff (!rst_n)
        batt_sel |-> (lockout && hiz));

    a_r7_battery_exit_locked: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(batt_sel) |-> lockout);

    a_r8_unlock_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lockout) |-> ($past(filt) == 3'b111));

    a_r9_good_single: assert property (@(posedge clk) disable iff (!rst_n)
        good |=> !good);

    a_r10_fail_single: assert property (@(posedge clk) disable iff (!rst_n)
        fail |=> !fail);

    a_r10_fail_locks: assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> lockout);

    a_r9_pulses_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(good && fail));
endmodule

bind supply_guard supply_guard_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .filt     (flag_filt),
    .lockout  (acc_lockout),
    .hiz      (bus_hiz),
    .batt_sel (batt_select),
    .good     (pwr_good_pulse),
    .fail     (pwr_fail_pulse)
);

// File: tb/supply_guard_test.sv
`timescale 1ns/1ps
module supply_guard_test;
    localparam int DEB = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic f_full = 1'b0, f_trip = 1'b0, f_sw = 1'b0;
    logic acc_lockout, bus_hiz, batt_select, pwr_good_pulse, pwr_fail_pulse;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    bit model_on = 1'b0;

    always #4 clk = ~clk;

    supply_guard #(.DEB_CYCLES(DEB)) uut (
        .clk(clk), .rst_n(rst_n),
        .sup_above_full(f_full), .sup_above_trip(f_trip), .sup_above_switch(f_sw),
        .acc_lockout(acc_lockout), .bus_hiz(bus_hiz), .batt_select(batt_select),
        .pwr_good_pulse(pwr_good_pulse), .pwr_fail_pulse(pwr_fail_pulse)
    );

    // Level codes: 0 dead, 1 low, 2 mid, 3 full. States: 0 normal, 1 protect, 2 battery, 3 recover.
    function automatic int classify(bit [2:0] f);
        if (f == 3'b111) return 3;
        if (f == 3'b011) return 2;
        if (f == 3'b001) return 1;
        return 0;
    endfunction

    function automatic int next_state(int st, int lvl);
        case (st)
            0: return (lvl == 0) ? 2 : (lvl == 1) ? 1 : 0;
            1: return (lvl == 0) ? 2 : (lvl == 3) ? 0 : 1;
            2: return (lvl == 0) ? 2 : 3;
            default: return (lvl == 0) ? 2 : (lvl == 3) ? 0 : 3;
        endcase
    endfunction

    bit [2:0] m_filt;
    int m_cnt [3];
    int m_state;
    bit m_trip, m_good, m_fail;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_filt = '0; m_state = 2; m_trip = 0; m_good = 0; m_fail = 0;
            for (int i = 0; i < 3; i++) m_cnt[i] = 0;
        end else begin
            int lvl;
            bit now_trip;
            bit [2:0] raw;
            lvl = classify(m_filt);
            now_trip = (lvl >= 2);
            m_state = next_state(m_state, lvl);
            m_good = now_trip && !m_trip;
            m_fail = !now_trip && m_trip;
            m_trip = now_trip;
            raw = {f_full, f_trip, f_sw};
            for (int i = 0; i < 3; i++) begin
                if (raw[i] == m_filt[i]) m_cnt[i] = 0;
                else if (m_cnt[i] == DEB - 1) begin m_filt[i] = raw[i]; m_cnt[i] = 0; end
                else m_cnt[i]++;
            end
        end
    end

    task automatic check_bit(string req, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0b expected %0b at %0t", req, what, act, exp, $time);
        end
    endtask

    // Cycle-by-cycle comparison with the model, away from the active edge.
    always @(negedge clk) begin
        if (model_on && rst_n) begin
            check_bit("R8", "lockout vs model", acc_lockout, m_state != 0);
            check_bit("R5", "hiz vs model", bus_hiz, m_state != 0);
            check_bit("R6", "batt vs model", batt_select, m_state == 2);
            check_bit("R9", "good pulse vs model", pwr_good_pulse, m_good);
            check_bit("R10", "fail pulse vs model", pwr_fail_pulse, m_fail);
        end
    end

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic drive(bit [2:0] f);
        {f_full, f_trip, f_sw} = f;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check_bit("R1", "reset lockout", acc_lockout, 1'b1);
        check_bit("R1", "reset hiz", bus_hiz, 1'b1);
        check_bit("R1", "reset batt", batt_select, 1'b1);
        check_bit("R1", "reset pulses", pwr_good_pulse | pwr_fail_pulse, 1'b0);
        rst_n = 1'b1;
        model_on = 1'b1;
        tick(1);
        check_bit("R1", "post-reset batt", batt_select, 1'b1);

        drive(3'b111);
        tick(DEB);
        check_bit("R11", "batt held before latency", batt_select, 1'b1);
        tick(1);
        check_bit("R7", "recover drops battery", batt_select, 1'b0);
        check_bit("R7", "recover keeps lockout", acc_lockout, 1'b1);
        check_bit("R9", "good pulse on rise", pwr_good_pulse, 1'b1);
        tick(1);
        check_bit("R8", "unlock at full", acc_lockout, 1'b0);
        check_bit("R4", "normal hiz clear", bus_hiz, 1'b0);
        check_bit("R9", "good pulse one cycle", pwr_good_pulse, 1'b0);

        drive(3'b001);
        tick(DEB - 1);
        drive(3'b111);
        tick(DEB + 2);
        check_bit("R2", "short glitch ignored lockout", acc_lockout, 1'b0);
        check_bit("R2", "short glitch ignored fail", pwr_fail_pulse, 1'b0);

        drive(3'b011);
        tick(DEB + 3);
        check_bit("R4", "normal kept in mid band", acc_lockout, 1'b0);

        drive(3'b001);
        tick(DEB + 1);
        check_bit("R5", "protect lockout", acc_lockout, 1'b1);
        check_bit("R5", "protect hiz", bus_hiz, 1'b1);
        check_bit("R5", "protect no battery", batt_select, 1'b0);
        check_bit("R10", "fail pulse on drop", pwr_fail_pulse, 1'b1);

        drive(3'b011);
        tick(DEB + 3);
        check_bit("R8", "mid keeps protect locked", acc_lockout, 1'b1);
        drive(3'b111);
        tick(DEB + 1);
        check_bit("R8", "full leaves protect", acc_lockout, 1'b0);

        drive(3'b110);
        tick(DEB + 1);
        check_bit("R3", "inconsistent 110 selects battery", batt_select, 1'b1);
        check_bit("R10", "fail pulse on inconsistent", pwr_fail_pulse, 1'b1);

        drive(3'b111);
        tick(DEB + 4);
        check_bit("R7", "back to normal via recover", acc_lockout, 1'b0);
        drive(3'b101);
        tick(DEB + 1);
        check_bit("R3", "inconsistent 101 selects battery", batt_select, 1'b1);
        check_bit("R6", "battery locks", acc_lockout, 1'b1);

        for (int seg = 0; seg < 400; seg++) begin
            bit [2:0] pat;
            int hold;
            case ($urandom % 6)
                0: pat = 3'b111;
                1: pat = 3'b011;
                2: pat = 3'b001;
                3: pat = 3'b000;
                4: pat = 3'b111;
                default: pat = 3'($urandom);
            endcase
            hold = 1 + ($urandom % (3 * DEB));
            drive(pat);
            tick(hold);
        end

        model_on = 1'b0;
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule